// File: doc/BRIEF.md
# Virtual Address Translator with TLB and Two-Level Table Walk

This block turns a 32-bit virtual address into a physical address for one access of a given kind: read, write or instruction fetch. It first searches a small fully associative translation cache, comparing the page number against every entry at once. If no entry matches, or if a write hits an entry whose page is not yet marked dirty, a hardware walker reads the two-level page table from memory. The top 10 address bits select a directory entry and the next 10 bits select an entry in the second-level table. Each 4 KB page keeps its 12-bit offset unchanged.

The walker checks that the page is present and that the access is allowed. It then writes the page table entry back with its referenced flag set, and with its dirty flag set as well for a write. The entry goes into the cache and the physical address is returned. A missing page produces a page fault. A forbidden access produces a protection fault. Neither fault returns an address, touches the table or fills the cache. A flush input empties the cache.

The walker uses a single word-wide memory port with a request/acknowledge handshake. The directory's physical frame is an input, so the surrounding logic can switch address spaces by changing it and pulsing flush.

Top module: `vm_translator`

## Requirements
- R1: A successful translation returns `rsp_pa` = {PTE frame number (PTE bits 31:12), virtual address bits 11:0}, with both fault flags low.
- R2: A walk reads the directory word at byte address {dir_base, va[31:22], 2'b00}, then the table word at {directory entry bits 31:12, va[21:12], 2'b00}. Table and directory entries use bit 0 = present, bit 1 = read allowed, bit 2 = write allowed, bit 3 = execute allowed, bit 4 = referenced, bit 5 = dirty, bits 31:12 = frame.
- R3: A directory or table entry with bit 0 clear makes the response a page fault (`rsp_pfault`=1, `rsp_pa`=0). It causes no memory write and installs nothing in the cache, so a later access to the same page walks again.
- R4: Access codes are 0 = read, 1 = write, 2 = execute. An access not allowed by the entry's permission bits answers with `rsp_xfault`=1 and `rsp_pa`=0, and writes nothing. This holds whether the entry came from the cache or from a walk.
- R5: A permitted walk writes the table entry back with bit 4 set, and with bit 5 also set for a write. When both bits already hold those values, no write is issued.
- R6: On a cache hit, the response comes at the first clock edge after the edge that accepted the request, and no memory request is made.
- R7: A write that hits an entry cached with the dirty flag clear walks the table and writes bit 5 before it responds. The hit entry is refreshed in place, so the next write to that page hits without touching memory.
- R8: Misses fill cache entries in round-robin order starting at entry 0. When the cache is full, the oldest fill is the one evicted.
- R9: A `flush` pulse invalidates every cache entry and returns the fill pointer to entry 0 at the next edge. A flush wins over a fill in the same cycle.
- R10: Once `mem_req` is raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is seen.
- R11: No page number ever matches more than one valid cache entry.
- R12: After reset `busy`, `rsp_valid` and `mem_req` are low. A request is accepted when `req_valid` is high and `busy` is low. `busy` stays high until the response. `rsp_valid` is a one-cycle pulse, and the two fault flags are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all cache entries |
| dir_base | input | 20 | Physical frame holding the top-level directory |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy | output | 1 | Request in progress; new requests ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address (0 on a fault) |
| rsp_pfault | output | 1 | Page not present |
| rsp_xfault | output | 1 | Access not permitted |
| mem_req | output | 1 | Table memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the table word |
| mem_wdata | output | 32 | Entry written back |
| mem_ack | input | 1 | Memory has completed the request |
| mem_rdata | input | 32 | Word read, valid with mem_ack |

## Verification
The bench builds the translator with a four-entry cache and leaves the 10/10/12 address split and the 32-bit word at their defaults. With only four entries, a fifth distinct page is enough to wrap the round-robin pointer and force an eviction. This makes the choice of victim observable as a fresh walk on one page while its neighbours still hit. With the default split, the directory and table addresses the walker emits can be compared bit for bit against the formulas in the requirements.

// File: rtl/xlt_pkg.sv
// Package: shared types for the virtual address translator.
// Assumes: table entries are one memory word with the flag layout below.
package xlt_pkg;

    // Access kind presented with each request
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Walker sequencing states
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_DIR,
        S_PTE,
        S_WB,
        S_FILL
    } walk_st_e;

    // Flag positions inside a directory or table entry
    localparam int PTE_V   = 0;
    localparam int PTE_R   = 1;
    localparam int PTE_W   = 2;
    localparam int PTE_X   = 3;
    localparam int PTE_REF = 4;
    localparam int PTE_MOD = 5;

endpackage

// File: rtl/xlt_perm_check.sv
// Module: permission check for one access against a {x,w,r} right set.
// Assumes: the reserved access code is never permitted.
module xlt_perm_check
    import xlt_pkg::*;
(
    input  acc_e       acc,
    input  logic [2:0] rights,   // {exec, write, read}
    output logic       allowed
);

    // Pick the right that matches the access kind
    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = rights[0];
            ACC_WRITE: allowed = rights[1];
            ACC_EXEC:  allowed = rights[2];
            default:   allowed = 1'b0;
        endcase
    end

endmodule

// File: rtl/xlt_tlb_cam.sv
// Module: fully associative translation cache with round-robin fill.
// Assumes: at most one fill per cycle; flush has priority over fill;
// a fill with use_idx set overwrites the named entry in place.
module xlt_tlb_cam #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [VPN_W-1:0]     lk_vpn,
    output logic                 lk_hit,
    output logic [$clog2(ENTRIES > 1 ? ENTRIES : 2)-1:0] lk_idx,
    output logic [PFN_W-1:0]     lk_pfn,
    output logic [2:0]           lk_rights,
    output logic                 lk_mod,
    input  logic                 fill_en,
    input  logic                 fill_use_idx,
    input  logic [$clog2(ENTRIES > 1 ? ENTRIES : 2)-1:0] fill_idx,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PFN_W-1:0]     fill_pfn,
    input  logic [2:0]           fill_rights,
    input  logic                 fill_mod
);

    localparam int IDX_W = $clog2(ENTRIES > 1 ? ENTRIES : 2);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   vpn_q   [ENTRIES];
    logic [PFN_W-1:0]   pfn_q   [ENTRIES];
    logic [2:0]         right_q [ENTRIES];
    logic               mod_q   [ENTRIES];
    logic [IDX_W-1:0]   rr;
    logic [IDX_W-1:0]   widx;

    // One comparator per entry, all evaluated in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (vpn_q[g] == lk_vpn);
    end

    // OR-combine the matching entry's fields (match is one-hot or empty)
    always_comb begin
        lk_idx    = '0;
        lk_pfn    = '0;
        lk_rights = '0;
        lk_mod    = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_idx    = lk_idx | IDX_W'(i);
                lk_pfn    = lk_pfn | pfn_q[i];
                lk_rights = lk_rights | right_q[i];
                lk_mod    = lk_mod | mod_q[i];
            end
        end
    end

    assign lk_hit = |match;
    assign widx   = fill_use_idx ? fill_idx : rr;

    // Valid bits and replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            rr  <= '0;
        end else if (flush) begin
            vld <= '0;
            rr  <= '0;
        end else if (fill_en) begin
            vld[widx] <= 1'b1;
            if (!fill_use_idx) begin
                rr <= (rr == LAST) ? '0 : rr + 1'b1;
            end
        end
    end

    // Entry payload storage, written only on an accepted fill
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            vpn_q[widx]   <= fill_vpn;
            pfn_q[widx]   <= fill_pfn;
            right_q[widx] <= fill_rights;
            mod_q[widx]   <= fill_mod;
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)) else $error("two entries match one page"); // R11

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0)) else $error("entry survived flush"); // R9

endmodule

// File: rtl/xlt_walker.sv
// Module: request sequencer and two-level table walker.
// Handles lookup result, permission checks, table reads, flag writeback
// and cache fill. Assumes the memory holds a request until mem_ack and
// presents read data in the acknowledge cycle.
module xlt_walker
    import xlt_pkg::*;
#(
    parameter int LVL_W  = 10,
    parameter int OFF_W  = 12,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WORD_W-OFF_W-1:0]    dir_base,
    input  logic                       req_valid,
    input  logic [2*LVL_W+OFF_W-1:0]   req_va,
    input  logic [1:0]                 req_acc,
    output logic                       busy,
    output logic                       rsp_valid,
    output logic [WORD_W-1:0]          rsp_pa,
    output logic                       rsp_pfault,
    output logic                       rsp_xfault,
    output logic [2*LVL_W-1:0]         lk_vpn,
    input  logic                       lk_hit,
    input  logic [IDX_W-1:0]           lk_idx,
    input  logic [WORD_W-OFF_W-1:0]    lk_pfn,
    input  logic [2:0]                 lk_rights,
    input  logic                       lk_mod,
    output logic                       fill_en,
    output logic                       fill_use_idx,
    output logic [IDX_W-1:0]           fill_idx,
    output logic [WORD_W-OFF_W-1:0]    fill_pfn,
    output logic [2:0]                 fill_rights,
    output logic                       fill_mod,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [WORD_W-OFF_W+LVL_W+1:0] mem_addr,
    output logic [WORD_W-1:0]          mem_wdata,
    input  logic                       mem_ack,
    input  logic [WORD_W-1:0]          mem_rdata
);

    localparam int VA_W  = 2 * LVL_W + OFF_W;
    localparam int PFN_W = WORD_W - OFF_W;

    walk_st_e           st;
    logic [VA_W-1:0]    va_q;
    acc_e               acc_q;
    logic               hit_q;
    logic [IDX_W-1:0]   hidx_q;
    logic [PFN_W-1:0]   tbl_q;
    logic [WORD_W-1:0]  pte_q;
    logic [WORD_W-1:0]  pte_new;
    logic               tlb_ok;
    logic               pte_ok;
    logic               need_walk;

    // Rights check for a cached entry
    xlt_perm_check u_perm_tlb (
        .acc     (acc_q),
        .rights  (lk_rights),
        .allowed (tlb_ok)
    );

    // Rights check for an entry just read from the table
    xlt_perm_check u_perm_pte (
        .acc     (acc_q),
        .rights  ({mem_rdata[PTE_X], mem_rdata[PTE_W], mem_rdata[PTE_R]}),
        .allowed (pte_ok)
    );

    // Entry value after this access marks it referenced (and dirty on write)
    always_comb begin
        pte_new = mem_rdata;
        pte_new[PTE_REF] = 1'b1;
        if (acc_q == ACC_WRITE) pte_new[PTE_MOD] = 1'b1;
    end

    // A hit is usable unless it is a write to a page not yet cached dirty
    assign need_walk = !lk_hit || (acc_q == ACC_WRITE && !lk_mod);

    assign busy   = (st != S_IDLE);
    assign lk_vpn = va_q[VA_W-1:OFF_W];

    // Memory port: directory read, table read, or entry writeback
    assign mem_req   = (st == S_DIR) || (st == S_PTE) || (st == S_WB);
    assign mem_we    = (st == S_WB);
    assign mem_addr  = (st == S_DIR)
                     ? {dir_base, va_q[VA_W-1 -: LVL_W], 2'b00}
                     : {tbl_q, va_q[OFF_W +: LVL_W], 2'b00};
    assign mem_wdata = pte_q;

    // Cache fill from the settled entry, in place when refreshing a hit
    assign fill_en      = (st == S_FILL);
    assign fill_use_idx = hit_q;
    assign fill_idx     = hidx_q;
    assign fill_pfn     = pte_q[WORD_W-1:OFF_W];
    assign fill_rights  = {pte_q[PTE_X], pte_q[PTE_W], pte_q[PTE_R]};
    assign fill_mod     = pte_q[PTE_MOD];

    // Sequencer: accept, look up, walk, write back, fill, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            va_q       <= '0;
            acc_q      <= ACC_READ;
            hit_q      <= 1'b0;
            hidx_q     <= '0;
            tbl_q      <= '0;
            pte_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_pa     <= '0;
            rsp_pfault <= 1'b0;
            rsp_xfault <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q  <= req_va;
                        acc_q <= acc_e'(req_acc);
                        st    <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    if (lk_hit && !tlb_ok) begin
                        rsp_valid  <= 1'b1;
                        rsp_pa     <= '0;
                        rsp_pfault <= 1'b0;
                        rsp_xfault <= 1'b1;
                        st         <= S_IDLE;
                    end else if (!need_walk) begin
                        rsp_valid  <= 1'b1;
                        rsp_pa     <= {lk_pfn, va_q[OFF_W-1:0]};
                        rsp_pfault <= 1'b0;
                        rsp_xfault <= 1'b0;
                        st         <= S_IDLE;
                    end else begin
                        hit_q  <= lk_hit;
                        hidx_q <= lk_idx;
                        st     <= S_DIR;
                    end
                end
                S_DIR: begin
                    if (mem_ack) begin
                        if (!mem_rdata[PTE_V]) begin
                            rsp_valid  <= 1'b1;
                            rsp_pa     <= '0;
                            rsp_pfault <= 1'b1;
                            rsp_xfault <= 1'b0;
                            st         <= S_IDLE;
                        end else begin
                            tbl_q <= mem_rdata[WORD_W-1:OFF_W];
                            st    <= S_PTE;
                        end
                    end
                end
                S_PTE: begin
                    if (mem_ack) begin
                        if (!mem_rdata[PTE_V]) begin
                            rsp_valid  <= 1'b1;
                            rsp_pa     <= '0;
                            rsp_pfault <= 1'b1;
                            rsp_xfault <= 1'b0;
                            st         <= S_IDLE;
                        end else if (!pte_ok) begin
                            rsp_valid  <= 1'b1;
                            rsp_pa     <= '0;
                            rsp_pfault <= 1'b0;
                            rsp_xfault <= 1'b1;
                            st         <= S_IDLE;
                        end else begin
                            pte_q <= pte_new;
                            st    <= (pte_new != mem_rdata) ? S_WB : S_FILL;
                        end
                    end
                end
                S_WB: begin
                    if (mem_ack) st <= S_FILL;
                end
                S_FILL: begin
                    rsp_valid  <= 1'b1;
                    rsp_pa     <= {pte_q[WORD_W-1:OFF_W], va_q[OFF_W-1:0]};
                    rsp_pfault <= 1'b0;
                    rsp_xfault <= 1'b0;
                    st         <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
        else $error("memory request dropped or changed before ack"); // R10

    AST_WB_REF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[PTE_V] && mem_wdata[PTE_REF])
        else $error("writeback without referenced flag"); // R5

    AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && acc_q == ACC_WRITE |-> mem_wdata[PTE_MOD])
        else $error("write access writeback without dirty flag"); // R7

    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_pfault && rsp_xfault))
        else $error("both fault flags set"); // R12

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid)
        else $error("response strobe longer than one cycle"); // R12

    AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_pfault || rsp_xfault) |-> !$past(fill_en))
        else $error("cache filled on a faulting access"); // R3

endmodule

// File: rtl/vm_translator.sv
// Module: top of the virtual address translator.
// Joins the associative cache and the walker; the page number looked up
// is the one installed on a fill. Assumes OFF_W == LVL_W + 2 so a table
// word address fits the physical word width.
module vm_translator
    import xlt_pkg::*;
#(
    parameter int LVL_W       = 10,
    parameter int OFF_W       = 12,
    parameter int WORD_W      = 32,
    parameter int TLB_ENTRIES = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic [WORD_W-OFF_W-1:0]        dir_base,
    input  logic                           req_valid,
    input  logic [2*LVL_W+OFF_W-1:0]       req_va,
    input  logic [1:0]                     req_acc,
    output logic                           busy,
    output logic                           rsp_valid,
    output logic [WORD_W-1:0]              rsp_pa,
    output logic                           rsp_pfault,
    output logic                           rsp_xfault,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [WORD_W-OFF_W+LVL_W+1:0]  mem_addr,
    output logic [WORD_W-1:0]              mem_wdata,
    input  logic                           mem_ack,
    input  logic [WORD_W-1:0]              mem_rdata
);

    localparam int VPN_W = 2 * LVL_W;
    localparam int PFN_W = WORD_W - OFF_W;
    localparam int IDX_W = $clog2(TLB_ENTRIES > 1 ? TLB_ENTRIES : 2);

    logic [VPN_W-1:0] lk_vpn;
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic [PFN_W-1:0] lk_pfn;
    logic [2:0]       lk_rights;
    logic             lk_mod;
    logic             fill_en;
    logic             fill_use_idx;
    logic [IDX_W-1:0] fill_idx;
    logic [PFN_W-1:0] fill_pfn;
    logic [2:0]       fill_rights;
    logic             fill_mod;

    xlt_tlb_cam #(
        .ENTRIES (TLB_ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_tlb (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .lk_vpn       (lk_vpn),
        .lk_hit       (lk_hit),
        .lk_idx       (lk_idx),
        .lk_pfn       (lk_pfn),
        .lk_rights    (lk_rights),
        .lk_mod       (lk_mod),
        .fill_en      (fill_en),
        .fill_use_idx (fill_use_idx),
        .fill_idx     (fill_idx),
        .fill_vpn     (lk_vpn),
        .fill_pfn     (fill_pfn),
        .fill_rights  (fill_rights),
        .fill_mod     (fill_mod)
    );

    xlt_walker #(
        .LVL_W  (LVL_W),
        .OFF_W  (OFF_W),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .dir_base     (dir_base),
        .req_valid    (req_valid),
        .req_va       (req_va),
        .req_acc      (req_acc),
        .busy         (busy),
        .rsp_valid    (rsp_valid),
        .rsp_pa       (rsp_pa),
        .rsp_pfault   (rsp_pfault),
        .rsp_xfault   (rsp_xfault),
        .lk_vpn       (lk_vpn),
        .lk_hit       (lk_hit),
        .lk_idx       (lk_idx),
        .lk_pfn       (lk_pfn),
        .lk_rights    (lk_rights),
        .lk_mod       (lk_mod),
        .fill_en      (fill_en),
        .fill_use_idx (fill_use_idx),
        .fill_idx     (fill_idx),
        .fill_pfn     (fill_pfn),
        .fill_rights  (fill_rights),
        .fill_mod     (fill_mod),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata)
    );

endmodule

// File: tb/vm_translator_test.sv
`timescale 1ns/1ps
module vm_translator_test;

    localparam logic [19:0] DIRB = 20'h00010;
    localparam logic [5:0] F_V = 6'h01, F_R = 6'h02, F_W = 6'h04,
                           F_X = 6'h08, F_REF = 6'h10, F_MOD = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [19:0] dir_base = DIRB;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        busy, rsp_valid, rsp_pfault, rsp_xfault;
    logic [31:0] rsp_pa;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    logic [31:0] la_prev = '0;
    logic [31:0] la_last = '0;
    logic [31:0] mem [logic [29:0]];

    vm_translator #(.TLB_ENTRIES(4)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dir_base(dir_base),
        .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_pfault(rsp_pfault), .rsp_xfault(rsp_xfault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;

    // Memory model: acknowledge one cycle after a request is seen
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[31:2]] = mem_wdata;
                n_wr++;
            end else begin
                mem_rdata <= mem.exists(mem_addr[31:2]) ? mem[mem_addr[31:2]] : 32'h0;
                la_prev = la_last;
                la_last = mem_addr;
                n_rd++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pte(input logic [19:0] pfn, input logic [5:0] fl);
        return {pfn, 6'b0, fl};
    endfunction

    function automatic logic [19:0] tframe(input logic [9:0] d);
        return 20'h00100 + 20'(d);
    endfunction

    task automatic map(input logic [9:0] d, input logic [9:0] t, input logic [31:0] w);
        mem[{DIRB, d}] = {tframe(d), 12'h001};
        mem[{tframe(d), t}] = w;
    endtask

    function automatic logic [31:0] pte_at(input logic [9:0] d, input logic [9:0] t);
        return mem[{tframe(d), t}];
    endfunction

    task automatic access(input logic [31:0] va, input logic [1:0] acc,
                          output logic [31:0] pa, output logic pf, output logic xf,
                          output int lat, output logic bsy);
        @(negedge clk);
        req_va = va; req_acc = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        bsy = busy;
        lat = 0;
        while (!rsp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        pa = rsp_pa; pf = rsp_pfault; xf = rsp_xfault;
    endtask

    task automatic t_reset();
        chk("R12", "busy after reset", 32'(busy), 32'd0);
        chk("R12", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R12", "mem_req after reset", 32'(mem_req), 32'd0);
    endtask

    task automatic t_walk_and_hit();
        logic [31:0] pa; logic pf, xf, b; int lat, r0, w0;
        map(10'd1, 10'd2, mk_pte(20'h12345, F_V | F_R | F_W));
        r0 = n_rd; w0 = n_wr;
        access({10'd1, 10'd2, 12'habc}, 2'd0, pa, pf, xf, lat, b);
        chk("R1", "walk pa", pa, 32'h12345abc);
        chk("R1", "walk faults", {30'd0, pf, xf}, 32'd0);
        chk("R12", "busy while pending", 32'(b), 32'd1);
        chk("R2", "directory address", la_prev, {DIRB, 10'd1, 2'b00});
        chk("R2", "table address", la_last, {tframe(10'd1), 10'd2, 2'b00});
        chk("R2", "reads per walk", 32'(n_rd - r0), 32'd2);
        chk("R5", "read writeback count", 32'(n_wr - w0), 32'd1);
        chk("R5", "entry after read", pte_at(10'd1, 10'd2), mk_pte(20'h12345, F_V | F_R | F_W | F_REF));
        r0 = n_rd;
        access({10'd1, 10'd2, 12'h004}, 2'd0, pa, pf, xf, lat, b);
        chk("R6", "hit latency", 32'(lat), 32'd1);
        chk("R6", "hit memory reads", 32'(n_rd - r0), 32'd0);
        chk("R6", "hit pa", pa, 32'h12345004);
    endtask

    task automatic t_dirty_hit();
        logic [31:0] pa; logic pf, xf, b; int lat, r0, w0;
        r0 = n_rd; w0 = n_wr;
        access({10'd1, 10'd2, 12'h010}, 2'd1, pa, pf, xf, lat, b);
        chk("R7", "clean write hit walks", 32'(n_rd - r0), 32'd2);
        chk("R7", "clean write hit writes", 32'(n_wr - w0), 32'd1);
        chk("R7", "entry dirty", pte_at(10'd1, 10'd2), mk_pte(20'h12345, F_V | F_R | F_W | F_REF | F_MOD));
        chk("R7", "write pa", pa, 32'h12345010);
        r0 = n_rd; w0 = n_wr;
        access({10'd1, 10'd2, 12'h020}, 2'd1, pa, pf, xf, lat, b);
        chk("R7", "dirty write hit latency", 32'(lat), 32'd1);
        chk("R7", "dirty write hit memory", 32'(n_rd - r0 + n_wr - w0), 32'd0);
    endtask

    task automatic t_no_change_wb();
        logic [31:0] pa; logic pf, xf, b; int lat, w0;
        map(10'd1, 10'd3, mk_pte(20'h0abcd, F_V | F_X | F_REF));
        w0 = n_wr;
        access({10'd1, 10'd3, 12'h7f0}, 2'd2, pa, pf, xf, lat, b);
        chk("R5", "no write when flags already set", 32'(n_wr - w0), 32'd0);
        chk("R1", "exec pa", pa, 32'h0abcd7f0);
    endtask

    task automatic t_page_faults();
        logic [31:0] pa; logic pf, xf, b; int lat, r0, w0;
        w0 = n_wr;
        access({10'd5, 10'd0, 12'h000}, 2'd0, pa, pf, xf, lat, b);
        chk("R3", "absent directory fault", {30'd0, pf, xf}, 32'd2);
        chk("R3", "absent directory pa", pa, 32'd0);
        map(10'd1, 10'd7, mk_pte(20'h00777, F_R));
        access({10'd1, 10'd7, 12'h123}, 2'd0, pa, pf, xf, lat, b);
        chk("R3", "absent page fault", {30'd0, pf, xf}, 32'd2);
        chk("R3", "no write on fault", 32'(n_wr - w0), 32'd0);
        map(10'd1, 10'd7, mk_pte(20'h00777, F_V | F_R | F_REF));
        r0 = n_rd;
        access({10'd1, 10'd7, 12'h123}, 2'd0, pa, pf, xf, lat, b);
        chk("R3", "faulted page not cached", 32'(n_rd - r0), 32'd2);
        chk("R3", "pa after repair", pa, 32'h00777123);
    endtask

    task automatic t_protection();
        logic [31:0] pa; logic pf, xf, b; int lat, r0, w0;
        map(10'd1, 10'd8, mk_pte(20'h00888, F_V | F_R));
        w0 = n_wr;
        access({10'd1, 10'd8, 12'h000}, 2'd2, pa, pf, xf, lat, b);
        chk("R4", "walk exec denied", {30'd0, pf, xf}, 32'd1);
        chk("R4", "walk denied pa", pa, 32'd0);
        chk("R4", "walk denied no write", 32'(n_wr - w0), 32'd0);
        chk("R4", "entry untouched", pte_at(10'd1, 10'd8), mk_pte(20'h00888, F_V | F_R));
        r0 = n_rd;
        access({10'd1, 10'd2, 12'h000}, 2'd2, pa, pf, xf, lat, b);
        chk("R4", "cached exec denied", {30'd0, pf, xf}, 32'd1);
        chk("R4", "cached denial latency", 32'(lat), 32'd1);
        chk("R4", "cached denial memory", 32'(n_rd - r0), 32'd0);
    endtask

    task automatic t_flush();
        logic [31:0] pa; logic pf, xf, b; int lat, r0;
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        r0 = n_rd;
        access({10'd1, 10'd2, 12'h000}, 2'd0, pa, pf, xf, lat, b);
        chk("R9", "walk after flush", 32'(n_rd - r0), 32'd2);
    endtask

    task automatic t_round_robin();
        logic [31:0] pa; logic pf, xf, b; int lat, r0;
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i < 5; i++) begin
            map(10'd2, 10'(i), mk_pte(20'h00200 + 20'(i), F_V | F_R | F_REF));
            access({10'd2, 10'(i), 12'h055}, 2'd0, pa, pf, xf, lat, b);
            chk("R8", "fill pa", pa, {20'h00200 + 20'(i), 12'h055});
        end
        r0 = n_rd;
        access({10'd2, 10'd1, 12'h0}, 2'd0, pa, pf, xf, lat, b);
        chk("R8", "second fill still cached", 32'(n_rd - r0), 32'd0);
        access({10'd2, 10'd0, 12'h0}, 2'd0, pa, pf, xf, lat, b);
        chk("R8", "oldest fill evicted", 32'(n_rd - r0), 32'd2);
        r0 = n_rd;
        access({10'd2, 10'd2, 12'h0}, 2'd0, pa, pf, xf, lat, b);
        chk("R8", "third fill still cached", 32'(n_rd - r0), 32'd0);
        access({10'd2, 10'd1, 12'h0}, 2'd0, pa, pf, xf, lat, b);
        chk("R8", "second fill now evicted", 32'(n_rd - r0), 32'd2);
        chk("R11", "refilled page pa", pa, 32'h00201000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk_and_hit();
        t_dirty_hit();
        t_no_change_wb();
        t_page_faults();
        t_protection();
        t_flush();
        t_round_robin();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule